// File: doc/BRIEF.md
# Coincident-Selection Static RAM Array

This block is a small static RAM whose storage is a square grid of one-bit cells. Instead of a single decoder that turns the whole address into one word line, the address is split. The upper part feeds a row decoder, and the lower part feeds a column decoder. A cell takes part in an access only where an active row line crosses an active column line. The column decoder is gated by chip select, so a deselected array touches no cell.

A parameter picks one of two organizations over the same sixteen cells. The narrow organization is sixteen one-bit words. The wide organization is eight two-bit words, where each column-decoder output selects a neighbouring pair of columns. Writes are synchronous, on the rising clock edge. Reads are combinational from the address.

The read port has an explicit valid flag and drives zero whenever it is not reading. Several arrays can therefore share one output bus by ORing their outputs. This plays the role of a three-state driver without real high-impedance nets.

Top module: `cs_ram_array`

## Requirements
- R1: A synchronous active-high reset clears every cell. A read of any address after reset returns zero.
- R2: A cell changes only on a clock edge where its row line, its column line and the write control are all active.
- R3: With chip select low, no column line is active. Any write attempt, whatever its data, leaves every stored word unchanged.
- R4: With chip select and write control both high, the data input is stored at the addressed word on the rising clock edge.
- R5: With chip select high and write control low, the read output shows the word stored at the current address in the same cycle, with no clock edge needed.
- R6: The read valid flag is high only when chip select is high and write control is low. While the flag is low, the read data is all zeros.
- R7: In the narrow organization (4-bit address, 1-bit data), address bits 3:2 pick the row and bits 1:0 pick the column. Exactly one row line is active at all times, and every one of the 16 addresses is a distinct cell.
- R8: In the wide organization (3-bit address, 2-bit data), address bits 2:1 pick the row and bit 0 picks a column pair. Data bit b of the pair is held in column 2*pair+b. Both bits move in one access, and every one of the 8 addresses is a distinct word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all cells |
| cs | input | 1 | Chip select; enables the column decoder |
| we | input | 1 | Operation control: 1 = write, 0 = read |
| addr | input | 4 (narrow) / 3 (wide) | Word address, row bits on top |
| data_in | input | 1 (narrow) / 2 (wide) | Write data |
| rd_data | output | 1 (narrow) / 2 (wide) | Read data, zero when not reading |
| rd_valid | output | 1 | High while a read is being presented |

## Verification
The hardest fault to see from the ports is a decode fault. In that case a write reaches a second cell or misses its own, and a simple write-then-read of each address cannot expose it. The stimulus therefore uses walking patterns. For each target address, the target alone receives a nonzero value and every other word is rewritten to zero. Then all addresses are read back. This is done for both bit lanes in the wide organization, so any aliasing between rows, columns or lanes shows up. Writes attempted with chip select low use the inverted data of a known fill, so that any leak would flip stored bits.

// File: rtl/cs_ram_pkg.sv
package cs_ram_pkg;

    typedef enum logic {
        ORG_NARROW = 1'b0,
        ORG_WIDE   = 1'b1
    } org_e;

    function automatic int word_bits(org_e org);
        return (org == ORG_WIDE) ? 2 : 1;
    endfunction

    function automatic int lane_addr_bits(org_e org);
        return (org == ORG_WIDE) ? 1 : 0;
    endfunction

    function automatic int addr_bits(int row_bits, int col_bits, org_e org);
        return row_bits + col_bits - lane_addr_bits(org);
    endfunction

endpackage

// File: rtl/cs_line_decoder.sv
module cs_line_decoder #(
    parameter int IN_W = 2,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic              en,
    input  logic [IN_W-1:0]   code,
    output logic [OUT_N-1:0]  lines
);

    always_comb begin
        lines = '0;
        for (int i = 0; i < OUT_N; i++) begin
            if (en && (code == IN_W'(i))) begin
                lines[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cs_bit_cell.sv
module cs_bit_cell (
    input  logic clk,
    input  logic rst,
    input  logic row_sel,
    input  logic col_sel,
    input  logic wr,
    input  logic d,
    output logic q_gated
);

    logic q;
    logic hit;

    assign hit = row_sel & col_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (hit && wr) begin
            q <= d;
        end
    end

    assign q_gated = q & hit;

    AST_CELL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(row_sel && col_sel && wr) |=> $stable(q)); // R2

    AST_CELL_WRITES: assert property (@(posedge clk) disable iff (rst)
        (row_sel && col_sel && wr) |=> (q == $past(d))); // R4

endmodule

// File: rtl/cs_ram_array.sv
module cs_ram_array
    import cs_ram_pkg::*;
#(
    parameter org_e ORG      = ORG_NARROW,
    parameter int   ROW_BITS = 2,
    parameter int   COL_BITS = 2
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          cs,
    input  logic                                          we,
    input  logic [addr_bits(ROW_BITS, COL_BITS, ORG)-1:0] addr,
    input  logic [word_bits(ORG)-1:0]                     data_in,
    output logic [word_bits(ORG)-1:0]                     rd_data,
    output logic                                          rd_valid
);

    localparam int DW       = word_bits(ORG);
    localparam int AW       = addr_bits(ROW_BITS, COL_BITS, ORG);
    localparam int GRP_BITS = COL_BITS - lane_addr_bits(ORG);
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int COLS     = 1 << COL_BITS;
    localparam int GROUPS   = 1 << GRP_BITS;
    localparam int CELLS    = ROWS * COLS;

    logic [ROWS-1:0]     row_sel;
    logic [GROUPS-1:0]   grp_sel;
    logic [CELLS-1:0]    gated;
    logic [DW-1:0]       lane_or;

    // Row decoder: always enabled, upper address bits.
    cs_line_decoder #(.IN_W(ROW_BITS)) u_row_dec (
        .en    (1'b1),
        .code  (addr[AW-1 -: ROW_BITS]),
        .lines (row_sel)
    );

    // Column decoder: enabled by chip select, picks a group of DW columns.
    cs_line_decoder #(.IN_W(GRP_BITS)) u_col_dec (
        .en    (cs),
        .code  (addr[GRP_BITS-1:0]),
        .lines (grp_sel)
    );

    // Grid: column c belongs to group c/DW and carries data lane c%DW.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            cs_bit_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .row_sel (row_sel[r]),
                .col_sel (grp_sel[c / DW]),
                .wr      (we),
                .d       (data_in[c % DW]),
                .q_gated (gated[r * COLS + c])
            );
        end
    end

    always_comb begin
        lane_or = '0;
        for (int k = 0; k < CELLS; k++) begin
            lane_or[(k % COLS) % DW] = lane_or[(k % COLS) % DW] | gated[k];
        end
    end

    assign rd_valid = cs & ~we;
    assign rd_data  = rd_valid ? lane_or : '0;

    AST_NO_COL_WITHOUT_CS: assert property (@(posedge clk) disable iff (rst)
        !cs |-> (grp_sel == '0)); // R3

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)); // R6

    AST_ONE_ROW_LINE: assert property (@(posedge clk) disable iff (rst)
        $countones(row_sel) == 1); // R7

    AST_ONE_GROUP_WHEN_CS: assert property (@(posedge clk) disable iff (rst)
        cs |-> ($countones(grp_sel) == 1)); // R8

endmodule

// File: tb/sim_cs_ram_array.sv
module sim_cs_ram_array;
    import cs_ram_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // Narrow organization: 16 x 1
    logic       n_cs = 1'b0, n_we = 1'b0;
    logic [3:0] n_addr = '0;
    logic [0:0] n_din = '0;
    logic [0:0] n_dout;
    logic       n_vld;

    // Wide organization: 8 x 2
    logic       w_cs = 1'b0, w_we = 1'b0;
    logic [2:0] w_addr = '0;
    logic [1:0] w_din = '0;
    logic [1:0] w_dout;
    logic       w_vld;

    int checks = 0;
    int errors = 0;

    cs_ram_array #(.ORG(ORG_NARROW)) u0 (
        .clk(clk), .rst(rst), .cs(n_cs), .we(n_we), .addr(n_addr),
        .data_in(n_din), .rd_data(n_dout), .rd_valid(n_vld)
    );

    cs_ram_array #(.ORG(ORG_WIDE)) u1 (
        .clk(clk), .rst(rst), .cs(w_cs), .we(w_we), .addr(w_addr),
        .data_in(w_din), .rd_data(w_dout), .rd_valid(w_vld)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic n_write(input int a, input int d);
        @(negedge clk);
        n_cs = 1'b1; n_we = 1'b1; n_addr = 4'(a); n_din = 1'(d);
        #2;
        check("R6 narrow write idle", {30'd0, n_vld, n_dout}, 0);
        @(negedge clk);
        n_cs = 1'b0; n_we = 1'b0;
    endtask

    task automatic w_write(input int a, input int d);
        @(negedge clk);
        w_cs = 1'b1; w_we = 1'b1; w_addr = 3'(a); w_din = 2'(d);
        #2;
        check("R6 wide write idle", {29'd0, w_vld, w_dout}, 0);
        @(negedge clk);
        w_cs = 1'b0; w_we = 1'b0;
    endtask

    task automatic n_read(input int a, input int exp, input string req);
        @(negedge clk);
        n_cs = 1'b1; n_we = 1'b0; n_addr = 4'(a);
        #2;
        check(req, {30'd0, n_vld, n_dout}, 2 + exp);
        n_cs = 1'b0;
    endtask

    task automatic w_read(input int a, input int exp, input string req);
        @(negedge clk);
        w_cs = 1'b1; w_we = 1'b0; w_addr = 3'(a);
        #2;
        check(req, {29'd0, w_vld, w_dout}, 4 + exp);
        w_cs = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R1: every word reads zero after reset
        for (int a = 0; a < 16; a++) n_read(a, 0, "R1 narrow reset");
        for (int a = 0; a < 8; a++)  w_read(a, 0, "R1 wide reset");

        // R4 / R5: single write then same-cycle read
        n_write(5, 1);
        n_read(5, 1, "R4 R5 narrow write-read");
        w_write(6, 2);
        w_read(6, 2, "R4 R5 wide write-read");

        // R7 (with R2): walking one over the 16 narrow cells
        for (int t = 0; t < 16; t++) begin
            for (int a = 0; a < 16; a++) n_write(a, (a == t) ? 1 : 0);
            for (int a = 0; a < 16; a++) n_read(a, (a == t) ? 1 : 0, "R7 R2 narrow walk");
        end

        // R8 (with R2): walking value in each lane over the 8 wide words
        for (int t = 0; t < 8; t++) begin
            for (int p = 1; p <= 2; p++) begin
                for (int a = 0; a < 8; a++) w_write(a, (a == t) ? p : 0);
                for (int a = 0; a < 8; a++) w_read(a, (a == t) ? p : 0, "R8 R2 wide walk");
            end
        end

        // R3: known fill, then deselected writes of inverted data
        for (int a = 0; a < 16; a++) n_write(a, (a ^ (a >> 3)) & 1);
        for (int a = 0; a < 8; a++)  w_write(a, (a * 3 + 1) & 3);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            n_cs = 1'b0; n_we = 1'b1; n_addr = 4'(a);
            n_din = 1'(~((a ^ (a >> 3)) & 1));
            #2;
            check("R6 R3 narrow deselected", {30'd0, n_vld, n_dout}, 0);
        end
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            w_cs = 1'b0; w_we = 1'b1; w_addr = 3'(a);
            w_din = 2'(~((a * 3 + 1) & 3));
            #2;
            check("R6 R3 wide deselected", {29'd0, w_vld, w_dout}, 0);
        end
        @(negedge clk);
        n_we = 1'b0; w_we = 1'b0;
        for (int a = 0; a < 16; a++) n_read(a, (a ^ (a >> 3)) & 1, "R3 narrow unchanged");
        for (int a = 0; a < 8; a++)  w_read(a, (a * 3 + 1) & 3, "R3 wide unchanged");

        // R1: reset in mid-run clears the filled arrays
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 16; a++) n_read(a, 0, "R1 narrow mid reset");
        for (int a = 0; a < 8; a++)  w_read(a, 0, "R1 wide mid reset");

        finish_run();
    end

endmodule